// File: doc/BRIEF.md
# Auxiliary regulator enable hysteresis controller

This controller sits beside a main switching converter that shares its output with a parallel auxiliary linear regulator. An analog overload detector raises an asynchronous request whenever the load goes beyond what the main converter can deliver. That request switches the auxiliary regulator on at once, through a purely combinational path. Turning it off again is a clocked decision made by this block.

While the block holds the auxiliary regulator on, it asks for load measurement to be enabled. It then compares each valid load sample with a programmed disable threshold. A sample is a percentage of the main converter's maximum load. The regulator is released only when two conditions hold together: a guaranteed minimum-on window has run out, and a sample is strictly below the threshold. If the overload request is still active at that point, the window restarts instead. This hysteresis stops the regulator from toggling on and off when the load sits close to the converter's limit.

Top module: `aux_reg_hyst_ctrl`

## Requirements
- R1: `aux_en_o` is high in the same cycle as `ovl_req_i`, with no clock edge in between, whatever the values of `en_i` and the internal state.
- R2: `ovl_req_i` passes through a two-flop synchronizer. With `en_i` high, a request that is high before rising edge 1 makes the hold state set on rising edge 3, and `meas_req_o` rises after that edge.
- R3: `meas_req_o` is high exactly while the block holds the regulator on. During that time `aux_en_o` stays high even after `ovl_req_i` has fallen.
- R4: `load_i` is an unsigned 7-bit percentage. Any value above 100 is treated as 100 before it is compared.
- R5: A release happens only on an edge where `load_vld_i` is high and the clamped load is strictly less than `thr_i`. A sample equal to the threshold keeps the regulator on.
- R6: When the hold state sets, the window counter loads `win_len_i` and then counts down by one on each edge until it reaches 0. Samples taken while the counter is non-zero have no effect. The earliest release is on edge `win_len_i`+1 after the set edge.
- R7: If the synchronized overload request is high on an edge where the release conditions are met, the hold stays on and the counter reloads `win_len_i`.
- R8: While `en_i` is low, `aux_en_o` equals `ovl_req_i`, `meas_req_o` is low, and both the hold state and the counter are cleared.
- R9: While `rst_ni` is low, the hold state, the synchronizer and the counter are cleared, and `meas_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable for the hysteresis logic |
| ovl_req_i | input | 1 | Asynchronous overload request from the analog detector |
| load_i | input | 7 | Load sample, percent of the main converter's maximum load |
| load_vld_i | input | 1 | Strobe marking `load_i` as a new sample |
| thr_i | input | 7 | Disable threshold, percent |
| win_len_i | input | 16 | Minimum-on window, in clock cycles |
| aux_en_o | output | 1 | Auxiliary regulator enable |
| meas_req_o | output | 1 | Load measurement enable request |

## Verification
Two events can fall on the same edge:
- A qualifying low-load sample that arrives just as the window expires.
- An overload request that is still synchronized high at that moment. This edge must reload the window rather than release the regulator.

To provoke this, the bench holds the overload request high and streams low samples on every cycle, so the counter keeps reaching zero with a valid sample waiting. It also places samples exactly one edge before and on the expiry edge, and equal to the threshold. The per-clock reference model judges each of these edges on both outputs.

// File: rtl/aux_hyst_pkg.sv
package aux_hyst_pkg;
  localparam int unsigned LOAD_W = 7;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned MAX_PCT = 100;

  typedef logic [LOAD_W-1:0] pct_t;
  typedef logic [CNT_W-1:0]  win_t;

  function automatic pct_t clamp_pct(input pct_t v);
    return (v > pct_t'(MAX_PCT)) ? pct_t'(MAX_PCT) : v;
  endfunction
endpackage

// File: rtl/aux_sync_2ff.sv
module aux_sync_2ff #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/aux_win_cnt.sv
module aux_win_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clr_i)        cnt_q <= '0;
    else if (load_i)       cnt_q <= len_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/aux_load_cmp.sv
module aux_load_cmp
  import aux_hyst_pkg::*;
(
  input  pct_t load_i,
  input  pct_t thr_i,
  output pct_t load_c_o,
  output logic below_o
);
  assign load_c_o = clamp_pct(load_i);
  assign below_o  = (load_c_o < thr_i);
endmodule

// File: rtl/aux_reg_hyst_ctrl.sv
module aux_reg_hyst_ctrl
  import aux_hyst_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ovl_req_i,
  input  logic [LOAD_W-1:0] load_i,
  input  logic              load_vld_i,
  input  logic [LOAD_W-1:0] thr_i,
  input  logic [CNT_W-1:0]  win_len_i,
  output logic              aux_en_o,
  output logic              meas_req_o
);
  logic ovl_s;
  logic hold_q;
  logic below, cnt_zero, rel_ok;
  logic cnt_clr, cnt_load, cnt_dec;
  pct_t load_c;
  win_t cnt;

  aux_sync_2ff #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ovl_req_i),
    .q_o   (ovl_s)
  );

  aux_load_cmp u_cmp (
    .load_i  (load_i),
    .thr_i   (thr_i),
    .load_c_o(load_c),
    .below_o (below)
  );

  // release condition: window expired and a valid low sample
  assign rel_ok   = hold_q && cnt_zero && load_vld_i && below;
  assign cnt_clr  = !en_i;
  assign cnt_load = en_i && ((!hold_q && ovl_s) || (rel_ok && ovl_s));
  assign cnt_dec  = en_i && hold_q;

  aux_win_cnt #(.CNT_W(CNT_W)) u_win (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .load_i(cnt_load),
    .dec_i (cnt_dec),
    .len_i (win_len_i),
    .cnt_o (cnt),
    .zero_o(cnt_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hold_q <= 1'b0;
    else if (!en_i)              hold_q <= 1'b0;
    else if (!hold_q && ovl_s)   hold_q <= 1'b1;
    else if (rel_ok && !ovl_s)   hold_q <= 1'b0;
  end

  // fast path: analog request bypasses all clocked logic
  assign aux_en_o   = ovl_req_i | (en_i & hold_q);
  assign meas_req_o = en_i & hold_q;
endmodule

// File: rtl/aux_hyst_chk.sv
module aux_hyst_chk
  import aux_hyst_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             ovl_req_i,
  input logic             load_vld_i,
  input logic [LOAD_W-1:0] thr_i,
  input logic [CNT_W-1:0] win_len_i,
  input logic             aux_en_o,
  input logic             meas_req_o,
  input logic             ovl_s,
  input pct_t             load_c,
  input win_t             cnt
);
  AST_FAST_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovl_req_i |-> aux_en_o); // R1

  AST_HOLD_KEEPS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_req_o |-> aux_en_o); // R3

  AST_OFF_WHEN_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !meas_req_o); // R8

  AST_NO_EARLY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_req_o && en_i && cnt != '0) |=> meas_req_o || !en_i); // R6

  AST_DROP_NEEDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(meas_req_o) && $past(en_i) && en_i) |->
      $past(load_vld_i && (load_c < thr_i))); // R5

  AST_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_c <= pct_t'(MAX_PCT)); // R4

  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_req_o && en_i && cnt == '0 && load_vld_i && load_c < thr_i && ovl_s)
      |=> (meas_req_o || !en_i) && (cnt == $past(win_len_i) || !en_i)); // R7
endmodule

bind aux_reg_hyst_ctrl aux_hyst_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .ovl_req_i (ovl_req_i),
  .load_vld_i(load_vld_i),
  .thr_i     (thr_i),
  .win_len_i (win_len_i),
  .aux_en_o  (aux_en_o),
  .meas_req_o(meas_req_o),
  .ovl_s     (ovl_s),
  .load_c    (load_c),
  .cnt       (cnt)
);

// File: tb/tb_aux_reg_hyst_ctrl.sv
module tb_aux_reg_hyst_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        ovl_req_i = 1'b0;
  logic [6:0]  load_i = '0;
  logic        load_vld_i = 1'b0;
  logic [6:0]  thr_i = 7'd30;
  logic [15:0] win_len_i = 16'd8;
  logic        aux_en_o, meas_req_o;

  int n_cmp = 0, n_bad = 0;
  string cur = "R9";
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  aux_reg_hyst_ctrl dut (.*);

  // behavioural reference
  int m_s1, m_s2, m_hold, m_cnt;
  always @(posedge clk_i or negedge rst_ni) begin
    int lc;
    bit rel;
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0; m_hold = 0; m_cnt = 0;
    end else begin
      lc  = (load_i > 100) ? 100 : int'(load_i);
      rel = load_vld_i && (lc < int'(thr_i)) && (m_cnt == 0);
      if (!en_i) begin m_hold = 0; m_cnt = 0; end
      else if (m_hold == 0) begin
        if (m_s2 != 0) begin m_hold = 1; m_cnt = int'(win_len_i); end
      end else if (m_cnt != 0) m_cnt = m_cnt - 1;
      else if (rel) begin
        if (m_s2 != 0) m_cnt = int'(win_len_i);
        else m_hold = 0;
      end
      m_s2 = m_s1;
      m_s1 = int'(ovl_req_i);
    end
  end

  task automatic compare();
    bit e_aux, e_meas;
    e_aux  = ovl_req_i || (rst_ni && en_i && m_hold != 0);
    e_meas = rst_ni && en_i && m_hold != 0;
    n_cmp += 2;
    if (aux_en_o !== e_aux) begin
      n_bad++;
      $display("FAIL %s aux_en_o act=%b exp=%b t=%0t", cur, aux_en_o, e_aux, $time);
    end
    if (meas_req_o !== e_meas) begin
      n_bad++;
      $display("FAIL %s meas_req_o act=%b exp=%b t=%0t", cur, meas_req_o, e_meas, $time);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      compare();
    end
  endtask

  task automatic sample(logic [6:0] v);
    load_i = v; load_vld_i = 1'b1;
    cyc(1);
    load_vld_i = 1'b0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cur = "R9"; cyc(3);
    ovl_req_i = 1'b1; #1; compare(); cyc(2); ovl_req_i = 1'b0;
    rst_ni = 1'b1; cyc(2);

    // disabled: follow request only
    cur = "R8"; ovl_req_i = 1'b1; #1; compare(); cyc(6);
    ovl_req_i = 1'b0; cyc(3);

    // window and threshold
    cur = "R2"; en_i = 1'b1; cyc(2);
    ovl_req_i = 1'b1; #1; compare(); cyc(4);
    cur = "R3"; ovl_req_i = 1'b0; cyc(2);
    cur = "R6"; sample(7'd5); sample(7'd5); cyc(2); sample(7'd5); cyc(3);
    cur = "R5"; sample(7'd30); cyc(1); sample(7'd31); sample(7'd29); cyc(3);

    // expiry edge: W=3, samples around the expiry
    cur = "R6"; win_len_i = 16'd3;
    ovl_req_i = 1'b1; cyc(1); ovl_req_i = 1'b0; cyc(3);
    sample(7'd1); sample(7'd1); sample(7'd1); sample(7'd1); cyc(3);

    // clamp
    cur = "R4"; thr_i = 7'd101; win_len_i = 16'd0;
    ovl_req_i = 1'b1; cyc(1); ovl_req_i = 1'b0; cyc(5);
    sample(7'd120); cyc(3);
    thr_i = 7'd100;
    ovl_req_i = 1'b1; cyc(1); ovl_req_i = 1'b0; cyc(5);
    sample(7'd127); sample(7'd100); cyc(1); sample(7'd99); cyc(3);

    // overload persists at release time
    cur = "R7"; thr_i = 7'd50; win_len_i = 16'd4;
    ovl_req_i = 1'b1; cyc(4);
    load_i = 7'd10; load_vld_i = 1'b1; cyc(20);
    ovl_req_i = 1'b0; cyc(12); load_vld_i = 1'b0; cyc(3);

    // enable dropped while holding
    cur = "R8"; win_len_i = 16'd50;
    ovl_req_i = 1'b1; cyc(2); ovl_req_i = 1'b0; cyc(6);
    en_i = 1'b0; cyc(4);
    ovl_req_i = 1'b1; #1; compare(); cyc(4); ovl_req_i = 1'b0; cyc(3);
    en_i = 1'b1; cyc(3);

    // reset mid-hold
    cur = "R9"; ovl_req_i = 1'b1; cyc(2); ovl_req_i = 1'b0; cyc(6);
    rst_ni = 1'b0; #1; compare(); cyc(3); rst_ni = 1'b1; cyc(4);

    // mid-cycle asynchronous pulse
    cur = "R1"; #1; ovl_req_i = 1'b1; #1; compare();
    ovl_req_i = 1'b0; #1; compare(); cyc(6);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule